// File: doc/BRIEF.md
# Programmable Bit-Rate Divider with Rate Learning

This block produces the bit-rate strobe shared by a serial port's transmit and receive engines. A divisor register, written from outside, sets how many system clocks lie between strobes. Three mode inputs pick a fixed prescale factor that multiplies the divisor: the synchronous/asynchronous selection, a wide-divisor enable and a fast-rate select. When the wide enable is low, only the lower half of the divisor register is used.

The block can also learn the rate from the line. Once armed, it waits for a 55h calibration character on the receive line and times the clocks from the character's first falling edge to its fifth, which is eight bit times. It divides that count by eight times the current prescale factor and writes the result into the divisor register. It then disarms itself. If the measurement counter reaches its limit before the fifth edge, it raises a rollover flag, disarms itself and leaves the divisor as it was.

Top module: `brg_autobaud`

## Requirements
- R1: With sync_mode=0, wide_en=0 and hi_speed=0, bit_tick pulses once every 64·(n+1) clocks, where n is the low half of the divisor.
- R2: With sync_mode=0, wide_en=0 and hi_speed=1, bit_tick pulses once every 16·(n+1) clocks.
- R3: With sync_mode=0 and wide_en=1, the full divisor n applies, and bit_tick pulses every 16·(n+1) clocks with hi_speed=0 and every 4·(n+1) clocks with hi_speed=1.
- R4: With sync_mode=1, bit_tick pulses every 4·(n+1) clocks whatever hi_speed is, with n the full divisor if wide_en=1 and the low half otherwise.
- R5: With wide_en=0, the upper half of the divisor has no effect on the bit_tick period.
- R6: A write (div_wr high at a clock edge) restarts the count. The first bit_tick comes M·(n+1) clocks after the edge that follows the write edge, where M is the prescale factor. bit_tick is one clock wide, and n=0 gives a strobe every M clocks.
- R7: abd_req while idle sets abd_busy. The block then times T clocks from the first to the fifth falling edge of rx_in (idle high). It writes floor(T/(8·M))−1 into the divisor and clears abd_busy, and div_value shows the learned value.
- R8: If the measurement counter of 2·HALF_W+9 bits reaches all ones before the fifth edge, abd_ovf goes high, abd_busy clears and the divisor keeps its value.
- R9: Arming clears abd_ovf. abd_busy only rises in the clock after abd_req.
- R10: After reset, bit_tick, abd_busy and abd_ovf are low and div_value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1 = synchronous rate (prescale 4) |
| wide_en | input | 1 | 1 = use the full divisor, 0 = use the low half only |
| hi_speed | input | 1 | Fast-rate select in asynchronous mode |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 2·HALF_W | Divisor write value |
| abd_req | input | 1 | Arm rate learning |
| rx_in | input | 1 | Receive line, idle high |
| bit_tick | output | 1 | One-clock bit-rate strobe |
| abd_busy | output | 1 | Rate learning in progress |
| abd_ovf | output | 1 | Measurement counter hit its limit |
| div_value | output | 2·HALF_W | Current divisor register |

## Verification
The bench builds the block with HALF_W=3, which gives a 6-bit divisor and a 15-bit measurement counter. With that counter, a receive line held low reaches the rollover limit in about 32 thousand clocks, so the rollover path is exercised within a short run. A 3-bit low half also makes the ignored upper bits easy to set in the narrow mode. Prescale factors of 4, 16 and 64 are each exercised by both the divider and the learning path.

// File: rtl/brg_pkg.sv
package brg_pkg;
  // prescale counter width covers the largest factor (64)
  localparam int PRE_W = 6;

  // log2 of the prescale factor chosen by the mode inputs
  function automatic logic [2:0] pre_shift(input logic sync_mode,
                                           input logic wide_en,
                                           input logic hi_speed);
    if (sync_mode)    return 3'd2;
    else if (wide_en) return hi_speed ? 3'd2 : 3'd4;
    else              return hi_speed ? 3'd4 : 3'd6;
  endfunction
endpackage

// File: rtl/brg_mode_dec.sv
module brg_mode_dec #(
  parameter int HALF_W = 8,
  localparam int DIV_W = 2 * HALF_W
) (
  input  logic             sync_mode,
  input  logic             wide_en,
  input  logic             hi_speed,
  input  logic [DIV_W-1:0] div_reg,
  output logic [2:0]       pre_sh,
  output logic [DIV_W-1:0] n_eff
);
  import brg_pkg::*;

  assign pre_sh = pre_shift(sync_mode, wide_en, hi_speed);
  assign n_eff  = wide_en ? div_reg : {{HALF_W{1'b0}}, div_reg[HALF_W-1:0]};
endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] n_eff,
  input  logic [2:0]       pre_sh,
  output logic             bit_tick
);
  import brg_pkg::*;

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] dcnt;
  logic [PRE_W:0]   one_sh;
  logic [PRE_W:0]   lim_full;
  logic [PRE_W-1:0] pre_lim;

  assign one_sh   = {{PRE_W{1'b0}}, 1'b1} << pre_sh;
  assign lim_full = one_sh - {{PRE_W{1'b0}}, 1'b1};
  assign pre_lim  = lim_full[PRE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt  <= '0;
      dcnt     <= '0;
      bit_tick <= 1'b0;
    end else begin
      bit_tick <= 1'b0;
      if (load) begin
        pre_cnt <= '0;
        dcnt    <= n_eff;
      end else if (pre_cnt >= pre_lim) begin
        pre_cnt <= '0;
        if (dcnt == '0) begin
          bit_tick <= 1'b1;
          dcnt     <= n_eff;
        end else begin
          dcnt <= dcnt - 1'b1;
        end
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/brg_abd.sv
module brg_abd #(
  parameter int DIV_W = 16,
  localparam int MEAS_W = DIV_W + 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             rx_in,
  input  logic [2:0]       pre_sh,
  output logic             busy,
  output logic             ovf,
  output logic             wb_valid,
  output logic [DIV_W-1:0] wb_data
);
  logic              rx_s1, rx_s2, rx_prev;
  logic              started;
  logic [2:0]        edge_cnt;
  logic [MEAS_W-1:0] meas;
  logic              fall;
  logic [3:0]        sh;
  logic [MEAS_W-1:0] quo, quo_m1;
  logic [DIV_W-1:0]  scaled;

  assign fall = rx_prev & ~rx_s2;

  // scale the 8-bit-time count to the current prescale factor
  always_comb begin
    sh     = {1'b0, pre_sh} + 4'd3;
    quo    = meas >> sh;
    quo_m1 = (quo == '0) ? '0 : quo - 1'b1;
    scaled = (|quo_m1[MEAS_W-1:DIV_W]) ? '1 : quo_m1[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s1    <= 1'b1;
      rx_s2    <= 1'b1;
      rx_prev  <= 1'b1;
      busy     <= 1'b0;
      ovf      <= 1'b0;
      started  <= 1'b0;
      edge_cnt <= '0;
      meas     <= '0;
      wb_valid <= 1'b0;
      wb_data  <= '0;
    end else begin
      rx_s1    <= rx_in;
      rx_s2    <= rx_s1;
      rx_prev  <= rx_s2;
      wb_valid <= 1'b0;
      if (arm && !busy) begin
        busy     <= 1'b1;
        ovf      <= 1'b0;
        started  <= 1'b0;
        edge_cnt <= '0;
        meas     <= '0;
      end else if (busy) begin
        if (!started) begin
          if (fall) begin
            started  <= 1'b1;
            meas     <= {{(MEAS_W-1){1'b0}}, 1'b1};
            edge_cnt <= 3'd1;
          end
        end else if (fall && edge_cnt == 3'd4) begin
          busy     <= 1'b0;
          wb_valid <= 1'b1;
          wb_data  <= scaled;
        end else begin
          if (fall) edge_cnt <= edge_cnt + 1'b1;
          if (meas == '1) begin
            ovf  <= 1'b1;
            busy <= 1'b0;
          end else begin
            meas <= meas + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/brg_autobaud.sv
module brg_autobaud #(
  parameter int HALF_W = 8,
  localparam int DIV_W = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_mode,
  input  logic             wide_en,
  input  logic             hi_speed,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             abd_req,
  input  logic             rx_in,
  output logic             bit_tick,
  output logic             abd_busy,
  output logic             abd_ovf,
  output logic [DIV_W-1:0] div_value
);
  logic [DIV_W-1:0] div_reg;
  logic [DIV_W-1:0] n_eff;
  logic [DIV_W-1:0] wb_data;
  logic [2:0]       pre_sh;
  logic             wb_valid;
  logic             load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_reg <= '0;
      load_q  <= 1'b0;
    end else begin
      load_q <= div_wr | wb_valid;
      if (div_wr)        div_reg <= div_wdata;
      else if (wb_valid) div_reg <= wb_data;
    end
  end

  assign div_value = div_reg;

  brg_mode_dec #(.HALF_W(HALF_W)) u_dec (
    .sync_mode (sync_mode),
    .wide_en   (wide_en),
    .hi_speed  (hi_speed),
    .div_reg   (div_reg),
    .pre_sh    (pre_sh),
    .n_eff     (n_eff)
  );

  brg_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .load     (load_q),
    .n_eff    (n_eff),
    .pre_sh   (pre_sh),
    .bit_tick (bit_tick)
  );

  brg_abd #(.DIV_W(DIV_W)) u_abd (
    .clk      (clk),
    .rst      (rst),
    .arm      (abd_req),
    .rx_in    (rx_in),
    .pre_sh   (pre_sh),
    .busy     (abd_busy),
    .ovf      (abd_ovf),
    .wb_valid (wb_valid),
    .wb_data  (wb_data)
  );
endmodule

// File: rtl/brg_autobaud_chk.sv
module brg_autobaud_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_tick,
  input logic             abd_req,
  input logic             abd_busy,
  input logic             abd_ovf,
  input logic             div_wr,
  input logic [DIV_W-1:0] div_value
);
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick); // R6
  AST_ARM_CLEARS_OVF: assert property (@(posedge clk) disable iff (rst)
    (abd_req && !abd_busy) |=> (abd_busy && !abd_ovf)); // R9
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(abd_busy) |-> $past(abd_req)); // R9
  AST_OVF_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(abd_ovf) |-> !abd_busy); // R8
  AST_OVF_KEEPS_DIV: assert property (@(posedge clk) disable iff (rst)
    ($rose(abd_ovf) && !$past(div_wr)) |-> $stable(div_value)); // R8
endmodule

bind brg_autobaud brg_autobaud_chk #(.DIV_W(2 * HALF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_tick  (bit_tick),
  .abd_req   (abd_req),
  .abd_busy  (abd_busy),
  .abd_ovf   (abd_ovf),
  .div_wr    (div_wr),
  .div_value (div_value)
);

// File: tb/brg_autobaud_tb.sv
`timescale 1ns/1ps
module brg_autobaud_tb;
  localparam int HALF_W = 3;
  localparam int DIV_W  = 2 * HALF_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_mode = 1'b0, wide_en = 1'b0, hi_speed = 1'b0;
  logic div_wr = 1'b0;
  logic [DIV_W-1:0] div_wdata = '0;
  logic abd_req = 1'b0;
  logic rx_in = 1'b1;
  logic bit_tick, abd_busy, abd_ovf;
  logic [DIV_W-1:0] div_value;

  int total = 0, bad = 0, cyc = 0;
  bit active = 0, done = 0;
  int exp_q[$];
  string cur_tag = "";

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  brg_autobaud #(.HALF_W(HALF_W)) u_dut (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .wide_en(wide_en),
    .hi_speed(hi_speed), .div_wr(div_wr), .div_wdata(div_wdata),
    .abd_req(abd_req), .rx_in(rx_in), .bit_tick(bit_tick),
    .abd_busy(abd_busy), .abd_ovf(abd_ovf), .div_value(div_value)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop expected strobe cycles and compare
  always @(negedge clk) begin
    if (!rst && active && bit_tick) begin
      if (exp_q.size() == 0) chk({cur_tag, " unexpected tick cycle"}, cyc, -1);
      else chk({cur_tag, " tick cycle"}, cyc, exp_q.pop_front());
    end
  end

  // driver: write divisor, push expected strobe cycles, wait for drain
  task automatic rate_case(input string tag, input logic s, input logic w,
                           input logic h, input int v, input int m,
                           input int n, input int k);
    int c;
    @(negedge clk);
    sync_mode = s; wide_en = w; hi_speed = h;
    cur_tag = tag;
    @(negedge clk);
    div_wr = 1'b1; div_wdata = DIV_W'(v);
    c = cyc;
    for (int i = 1; i <= k; i++) exp_q.push_back(c + 2 + m * (n + 1) * i);
    @(negedge clk);
    div_wr = 1'b0;
    @(negedge clk);
    active = 1;
    for (int g = 0; g < m * (n + 1) * (k + 1) + 10 && exp_q.size() > 0; g++)
      @(negedge clk);
    active = 0;
    while (exp_q.size() > 0) chk({tag, " missing tick"}, 0, exp_q.pop_front());
  endtask

  task automatic arm();
    @(negedge clk);
    abd_req = 1'b1;
    @(negedge clk);
    abd_req = 1'b0;
  endtask

  task automatic send55(input int p);
    logic [9:0] fr;
    fr = {1'b1, 8'h55, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx_in = fr[i];
      repeat (p) @(negedge clk);
    end
    rx_in = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic tick_period(input string tag, input int exp);
    int t1;
    while (!bit_tick) @(negedge clk);
    t1 = cyc;
    @(negedge clk);
    while (!bit_tick) @(negedge clk);
    chk(tag, cyc - t1, exp);
  endtask

  task automatic learn(input string tag, input logic s, input logic w,
                       input logic h, input int m, input int nt);
    @(negedge clk);
    sync_mode = s; wide_en = w; hi_speed = h;
    arm();
    chk({tag, " busy after arm"}, int'(abd_busy), 1);
    send55(m * (nt + 1));
    chk({tag, " busy cleared"}, int'(abd_busy), 0);
    chk({tag, " learned divisor"}, int'(div_value), nt);
    chk({tag, " no rollover"}, int'(abd_ovf), 0);
    tick_period({tag, " learned period"}, m * (nt + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 tick in reset", int'(bit_tick), 0);
    chk("R10 divisor in reset", int'(div_value), 0);
    chk("R10 busy in reset", int'(abd_busy), 0);
    chk("R10 ovf in reset", int'(abd_ovf), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 divisor after reset", int'(div_value), 0);

    rate_case("R1 narrow slow", 0, 0, 0, 2, 64, 2, 3);
    rate_case("R2 narrow fast", 0, 0, 1, 4, 16, 4, 3);
    rate_case("R5 upper half ignored", 0, 0, 1, 'b101101, 16, 5, 3);
    rate_case("R3 wide slow", 0, 1, 0, 19, 16, 19, 3);
    rate_case("R3 wide fast", 0, 1, 1, 40, 4, 40, 3);
    rate_case("R4 sync speed0", 1, 0, 0, 3, 4, 3, 3);
    rate_case("R4 sync speed1", 1, 0, 1, 3, 4, 3, 3);
    rate_case("R4 sync wide", 1, 1, 0, 50, 4, 50, 3);
    rate_case("R6 zero divisor", 0, 0, 1, 0, 16, 0, 4);

    learn("R7 narrow slow", 0, 0, 0, 64, 3);
    learn("R7 wide fast", 0, 1, 1, 4, 37);

    // rollover: single falling edge, line then held low
    arm();
    rx_in = 1'b0;
    repeat (33000) @(negedge clk);
    chk("R8 ovf set", int'(abd_ovf), 1);
    chk("R8 busy cleared", int'(abd_busy), 0);
    chk("R8 divisor kept", int'(div_value), 37);
    rx_in = 1'b1;
    repeat (10) @(negedge clk);

    arm();
    chk("R9 ovf cleared by arm", int'(abd_ovf), 0);
    chk("R9 busy after arm", int'(abd_busy), 1);
    hi_speed = 1'b1; wide_en = 1'b0;
    send55(48);
    chk("R7 narrow fast learned", int'(div_value), 2);
    chk("R9 ovf still low", int'(abd_ovf), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule